// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block sits beside a memory array's access path. It watches each completed read cycle and looks for a fixed six-step key of read addresses. The first five reads must land on a fixed prefix, in a fixed order. The address of the sixth read then selects one of three commands: a nonvolatile store, a nonvolatile recall, or disabling the automatic store on power loss. The selected command does not issue at once. It issues only after a quiet window of `T_SS` clock cycles in which no further access is made.

A read is counted on the rising edge of the `rd_done` strobe. The strobe counts only when the chip is selected and the write enable is inactive, so reads framed by the chip select and reads framed by the output enable count the same way. Only address bits 14 down to 2 take part in the comparison. Any write, or any read that does not match the next expected step, abandons the sequence and raises a one-cycle abort pulse. When the abandoning read matches the first key step, it opens a fresh sequence.

Top module: `seqcmd_detector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all four output pulses are low. A reset also discards any partly entered sequence, so a sixth read after a reset issues nothing.
- R2: The comparison uses address bits 14 down to 2 only. Changing bits 1:0 or any bit above 14 does not change the outcome of a sequence.
- R3: The five prefix reads must hit 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, one after another in exactly that order.
- R4: A sixth read at 0x8FC0 leads to a one-cycle `store_o` pulse.
- R5: A sixth read at 0x4C63 leads to a one-cycle `recall_o` pulse.
- R6: A sixth read at 0x8B45 leads to a one-cycle `asdis_o` pulse.
- R7: When a sequence is in progress and a counted read does not match the expected step (prefix or final), `abort_o` pulses in the cycle after the read edge and no command issues. If that read matches 0x4E38, it counts as step one of a new sequence. A mismatched read while idle produces no pulse.
- R8: A write (`sel` and `wr` both high, counted on its rising edge) during a sequence pulses `abort_o` in the cycle after that edge. A write while idle produces no pulse.
- R9: The command pulse is high in the cycle that begins `T_SS` clock edges after the edge that captured the sixth read. Any read or write edge within those edges cancels it and pulses `abort_o` instead. At most one of the four outputs is high in any cycle.
- R10: A `rd_done` level held high for several cycles counts as one read. A `rd_done` edge while `sel` is low is ignored and does not disturb a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip selected, active high |
| wr | input | 1 | Write enable, active high |
| rd_done | input | 1 | Read cycle completed; its rising edge counts |
| addr | input | AW | Address of the current cycle |
| store_o | output | 1 | One-cycle store command |
| recall_o | output | 1 | One-cycle recall command |
| asdis_o | output | 1 | One-cycle autostore-disable command |
| abort_o | output | 1 | One-cycle sequence-abandoned indication |

## Verification
A wrong step count shows up at the very next read edge. Either a legal sequence is cut short by an abort one cycle after a correct read, or a read that should have aborted passes silently, which the scoreboard flags when the expected abort is missing. A wrong quiet-window count moves the command pulse away from the exact cycle that the scoreboard expects, or lets an access made late in the window slip through. A wrong command latch shows as the wrong one of the three pulses, `T_SS` cycles after the sixth read.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_STORE  = 2'd1,
      CMD_RECALL = 2'd2,
      CMD_ASDIS  = 2'd3
   } cmd_e;

   localparam int PREFIX_LEN = 5;
   localparam int CMP_HI     = 14;
   localparam int CMP_LO     = 2;

   // Unlock key: prefix steps 0..4, then the three command finals 5..7
   function automatic logic [15:0] key_of(input int idx);
      case (idx)
         0:       key_of = 16'h4E38;
         1:       key_of = 16'hB1C7;
         2:       key_of = 16'h83E0;
         3:       key_of = 16'h7C1F;
         4:       key_of = 16'h703F;
         5:       key_of = 16'h8FC0;
         6:       key_of = 16'h4C63;
         default: key_of = 16'h8B45;
      endcase
   endfunction

endpackage

// File: rtl/seqcmd_edge.sv
module seqcmd_edge #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '1;
      else     prev_q <= lvl;
   end

   for (genvar g = 0; g < W; g++) begin : g_bit
      assign rise[g] = lvl[g] & ~prev_q[g];
   end
endmodule

// File: rtl/seqcmd_match.sv
module seqcmd_match
   import seqcmd_pkg::*;
#(
   parameter int AW = 19
) (
   input  logic [AW-1:0]         addr,
   output logic [PREFIX_LEN-1:0] step_hit,
   output cmd_e                  fin_cmd
);
   localparam int CW = CMP_HI - CMP_LO + 1;

   if (AW <= CMP_HI) begin : g_bad_aw
      $error("seqcmd_match: AW must exceed %0d", CMP_HI);
   end

   logic [CW-1:0] field;
   logic [2:0]    fin_hit;

   assign field = addr[CMP_HI:CMP_LO];

   for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_prefix
      localparam logic [15:0] K = key_of(g);
      assign step_hit[g] = (field == K[CMP_HI:CMP_LO]);
   end

   for (genvar f = 0; f < 3; f++) begin : g_final
      localparam logic [15:0] K = key_of(PREFIX_LEN + f);
      assign fin_hit[f] = (field == K[CMP_HI:CMP_LO]);
   end

   always_comb begin
      if (fin_hit[0])      fin_cmd = CMD_STORE;
      else if (fin_hit[1]) fin_cmd = CMD_RECALL;
      else if (fin_hit[2]) fin_cmd = CMD_ASDIS;
      else                 fin_cmd = CMD_NONE;
   end
endmodule

// File: rtl/seqcmd_quiet.sv
module seqcmd_quiet #(
   parameter int T_SS = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic done
);
   localparam int TW = (T_SS < 2) ? 1 : $clog2(T_SS);
   localparam logic [TW-1:0] LAST = TW'(T_SS - 1);

   if (T_SS < 1) begin : g_bad_tss
      $error("seqcmd_quiet: T_SS must be at least 1");
   end

   logic [TW-1:0] cnt_q;

   assign done = run && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst || !run)  cnt_q <= '0;
      else if (!done)   cnt_q <= cnt_q + 1'b1;
   end

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST); // R9
endmodule

// File: rtl/seqcmd_detector.sv
module seqcmd_detector
   import seqcmd_pkg::*;
#(
   parameter int AW   = 19,
   parameter int T_SS = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sel,
   input  logic          wr,
   input  logic          rd_done,
   input  logic [AW-1:0] addr,
   output logic          store_o,
   output logic          recall_o,
   output logic          asdis_o,
   output logic          abort_o
);
   localparam int SW = $clog2(PREFIX_LEN + 1);
   localparam logic [SW-1:0] LAST_STEP = SW'(PREFIX_LEN);

   logic [1:0]            rise;
   logic                  rd_ev, wr_ev, access;
   logic [PREFIX_LEN-1:0] step_hit;
   cmd_e                  fin_cmd;
   logic [SW-1:0]         step_q;
   logic                  wait_q;
   cmd_e                  pend_q;
   logic                  quiet_done;
   logic                  busy;

   seqcmd_edge #(.W(2)) i_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  ({sel & wr, rd_done}),
      .rise (rise)
   );

   assign rd_ev  = rise[0] & sel & ~wr;
   assign wr_ev  = rise[1];
   assign access = rd_ev | wr_ev;
   assign busy   = wait_q || (step_q != '0);

   seqcmd_match #(.AW(AW)) i_match (
      .addr     (addr),
      .step_hit (step_hit),
      .fin_cmd  (fin_cmd)
   );

   seqcmd_quiet #(.T_SS(T_SS)) i_quiet (
      .clk  (clk),
      .rst  (rst),
      .run  (wait_q),
      .done (quiet_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q   <= '0;
         wait_q   <= 1'b0;
         pend_q   <= CMD_NONE;
         store_o  <= 1'b0;
         recall_o <= 1'b0;
         asdis_o  <= 1'b0;
         abort_o  <= 1'b0;
      end else begin
         store_o  <= 1'b0;
         recall_o <= 1'b0;
         asdis_o  <= 1'b0;
         abort_o  <= 1'b0;
         if (wait_q) begin
            if (access) begin
               abort_o <= 1'b1;
               wait_q  <= 1'b0;
               step_q  <= (rd_ev && step_hit[0]) ? SW'(1) : '0;
            end else if (quiet_done) begin
               store_o  <= (pend_q == CMD_STORE);
               recall_o <= (pend_q == CMD_RECALL);
               asdis_o  <= (pend_q == CMD_ASDIS);
               wait_q   <= 1'b0;
               step_q   <= '0;
            end
         end else if (wr_ev) begin
            abort_o <= (step_q != '0);
            step_q  <= '0;
         end else if (rd_ev) begin
            if (step_q == LAST_STEP && fin_cmd != CMD_NONE) begin
               wait_q <= 1'b1;
               pend_q <= fin_cmd;
               step_q <= '0;
            end else if (step_q != LAST_STEP && step_hit[step_q]) begin
               step_q <= step_q + 1'b1;
            end else begin
               abort_o <= (step_q != '0);
               step_q  <= step_hit[0] ? SW'(1) : '0;
            end
         end
      end
   end

   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({store_o, recall_o, asdis_o, abort_o})); // R9
   AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (rst)
      (wr_ev && busy) |=> abort_o); // R8
   AST_CMD_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
      $rose(store_o | recall_o | asdis_o) |-> !$past(access)); // R9
   AST_IDLE_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
      (store_o | recall_o | asdis_o) |-> !busy); // R4
   AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
      step_q <= LAST_STEP); // R3
endmodule

// File: tb/test_seqcmd_detector.sv
module test_seqcmd_detector;
   localparam int AW   = 19;
   localparam int T_SS = 8;

   // Pulse kinds as the bench sees them: {abort, asdis, recall, store}
   localparam logic [3:0] K_STORE  = 4'b0001;
   localparam logic [3:0] K_RECALL = 4'b0010;
   localparam logic [3:0] K_ASDIS  = 4'b0100;
   localparam logic [3:0] K_ABORT  = 4'b1000;

   typedef struct { int cyc; logic [3:0] kind; string req; } exp_t;

   logic clk = 1'b0, rst = 1'b1, sel = 1'b1, wr = 1'b0, rd_done = 1'b0;
   logic [AW-1:0] addr = '0;
   logic store_o, recall_o, asdis_o, abort_o;

   int   cyc = 0, checks = 0, errors = 0;
   exp_t q[$];
   logic [15:0] keys [6];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   seqcmd_detector #(.AW(AW), .T_SS(T_SS)) i_seqcmd_detector (
      .clk(clk), .rst(rst), .sel(sel), .wr(wr), .rd_done(rd_done), .addr(addr),
      .store_o(store_o), .recall_o(recall_o), .asdis_o(asdis_o), .abort_o(abort_o));

   function automatic logic [3:0] pulses();
      return {abort_o, asdis_o, recall_o, store_o};
   endfunction

   // monitor: compare every produced pulse against the scoreboard queue
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
         checks++; errors++;
         $display("FAIL %s: missing pulse at cycle %0d, actual=0000 expected=%b",
                  q[0].req, q[0].cyc, q[0].kind);
         void'(q.pop_front());
      end
      if (!rst && pulses() != 4'b0) begin
         checks++;
         if (q.size() > 0 && q[0].cyc == cyc && q[0].kind == pulses()) begin
            void'(q.pop_front());
         end else begin
            errors++;
            $display("FAIL %s: cycle %0d actual=%b expected=%b",
                     (q.size() > 0) ? q[0].req : "R9", cyc, pulses(),
                     (q.size() > 0 && q[0].cyc == cyc) ? q[0].kind : 4'b0);
            if (q.size() > 0 && q[0].cyc == cyc) void'(q.pop_front());
         end
      end
   end

   task automatic expect_at(input int c, input logic [3:0] k, input string req);
      exp_t e; e.cyc = c; e.kind = k; e.req = req; q.push_back(e);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input int hold, output int t);
      @(negedge clk); addr = a; rd_done = 1'b1; t = cyc;
      repeat (hold) @(negedge clk);
      rd_done = 1'b0;
   endtask

   task automatic do_write(output int t);
      @(negedge clk); wr = 1'b1; t = cyc;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // explicit quiet check: no pulse for n cycles
   task automatic no_pulse(input int n, input string req);
      logic seen = 1'b0;
      repeat (n) begin @(negedge clk); if (pulses() != 4'b0) seen = 1'b1; end
      checks++;
      if (seen) begin
         errors++; $display("FAIL %s: unexpected pulse, actual=1 expected=0", req);
      end
   endtask

   // reads keys[0..n-1] with mask applied through xr
   task automatic prefix(input int n, input logic [AW-1:0] xr);
      int t;
      for (int i = 0; i < n; i++) begin
         do_read({3'b0, keys[i]} ^ xr, 1, t); idle(1);
      end
   endtask

   task automatic full_seq(input logic [15:0] fin, input logic [3:0] k,
                           input logic [AW-1:0] xr, input string req);
      int t;
      prefix(5, xr);
      do_read({3'b0, fin} ^ xr, 1, t);
      expect_at(t + 1 + T_SS, k, req);
      idle(T_SS + 3);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int t;
      keys[0] = 16'h4E38; keys[1] = 16'hB1C7; keys[2] = 16'h83E0;
      keys[3] = 16'h7C1F; keys[4] = 16'h703F; keys[5] = 16'h8FC0;

      // R1: reset state
      idle(3);
      checks++;
      if (pulses() != 4'b0) begin
         errors++; $display("FAIL R1: in reset actual=%b expected=0000", pulses());
      end
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      checks++;
      if (pulses() != 4'b0) begin
         errors++; $display("FAIL R1: after reset actual=%b expected=0000", pulses());
      end

      // R3 R4 R5 R6: the three commands
      full_seq(16'h8FC0, K_STORE,  '0, "R4");
      full_seq(16'h4C63, K_RECALL, '0, "R5");
      full_seq(16'h8B45, K_ASDIS,  '0, "R6");

      // R2: bits 18:15 and 1:0 flipped on every step
      full_seq(16'h8FC0, K_STORE, 19'h78003, "R2");

      // R7: wrong prefix read aborts, no command
      prefix(3, '0);
      do_read(19'h01234, 1, t); expect_at(t + 1, K_ABORT, "R7");
      do_read(19'h08FC0, 1, t);
      no_pulse(T_SS + 3, "R7");

      // R7: aborting read equal to step one restarts the key
      prefix(3, '0);
      do_read(19'h04E38, 1, t); expect_at(t + 1, K_ABORT, "R7");
      idle(1);
      for (int i = 1; i < 5; i++) begin do_read({3'b0, keys[i]}, 1, t); idle(1); end
      do_read(19'h04C63, 1, t); expect_at(t + 1 + T_SS, K_RECALL, "R7");
      idle(T_SS + 3);

      // R7: wrong final address aborts
      prefix(5, '0);
      do_read(19'h00000, 1, t); expect_at(t + 1, K_ABORT, "R7");
      no_pulse(T_SS + 3, "R7");

      // R7: stray read while idle is silent
      do_read(19'h05555, 1, t);
      no_pulse(4, "R7");

      // R8: write mid-sequence aborts, write while idle is silent
      prefix(4, '0);
      do_write(t); expect_at(t + 1, K_ABORT, "R8");
      idle(2);
      do_write(t);
      no_pulse(4, "R8");

      // R9: read inside the quiet window cancels the command
      prefix(5, '0);
      do_read(19'h08FC0, 1, t);
      idle(T_SS - 3);
      do_read(19'h00100, 1, t); expect_at(t + 1, K_ABORT, "R9");
      no_pulse(T_SS + 3, "R9");

      // R9: write on the last edge of the window cancels the command
      prefix(5, '0);
      do_read(19'h08B45, 1, t);
      idle(T_SS - 2);
      do_write(t); expect_at(t + 1, K_ABORT, "R9");
      no_pulse(T_SS + 3, "R9");

      // R10: held strobe counts once, read with sel low is ignored
      prefix(2, '0);
      do_read(19'h083E0, 4, t); idle(1);
      @(negedge clk); sel = 1'b0; addr = 19'h00777; rd_done = 1'b1;
      @(negedge clk); rd_done = 1'b0;
      @(negedge clk); sel = 1'b1;
      do_read(19'h07C1F, 1, t); idle(1);
      do_read(19'h0703F, 1, t); idle(1);
      do_read(19'h08FC0, 1, t); expect_at(t + 1 + T_SS, K_STORE, "R10");
      idle(T_SS + 3);

      // R1: reset discards a partly entered sequence
      prefix(5, '0);
      @(negedge clk); rst = 1'b1;
      idle(2);
      rst = 1'b0;
      do_read(19'h08FC0, 1, t);
      no_pulse(T_SS + 3, "R1");

      idle(2);
      checks++;
      if (q.size() != 0) begin
         errors++; $display("FAIL R9: pending expectations actual=%0d expected=0", q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule